// File: doc/BRIEF.md
# Exception Entry and Return Controller

This block sits beside a processor pipeline and owns the current status register together with the banked link and saved-status registers of the five privileged modes. Each cycle it looks at the pending exception requests and masks IRQ and FIQ with the interrupt-disable bits of the current status. It then chooses a single winner by fixed priority. On the next clock edge it performs the entry. The return address goes into the link bank of the target mode, and the old status goes into that mode's saved-status bank. The mode field and the disable bits are rewritten, and the program counter is redirected to the exception's vector.

The block also carries out the return-from-exception step. When the pipeline asks for a return, the program counter is loaded from the active mode's link register and the status register from its saved copy, both in the same cycle. The pipeline can also overwrite the status register directly, for example to drop into User mode. Address width and instruction size are parameters.

Top module: `exc_entry_ctrl`

## Requirements
- R1: When several unmasked requests arrive in the same cycle, exactly one is accepted, in the order reset, data abort, FIQ, IRQ, instruction abort, undefined instruction, software interrupt (highest first).
- R2: `taken` is a one-hot strobe, high for exactly the one cycle after the request was sampled, with bit 0 reset, 1 undefined, 2 software interrupt, 3 instruction abort, 4 data abort, 5 IRQ, 6 FIQ.
- R3: On entry `pc_load` pulses for one cycle and `pc_out` carries the vector: reset 0x00, undefined 0x04, software interrupt 0x08, instruction abort 0x0C, data abort 0x10, IRQ 0x18, FIQ 0x1C. The offset 0x14 never appears.
- R4: Entry sets the status mode field (bits 4:0) to the target mode. Reset and software interrupt select Supervisor 10011, undefined selects Undefined 11011, both aborts select Abort 10111, IRQ selects IRQ 10010 and FIQ selects FIQ 10001. User is 10000.
- R5: Entry stores `pc_now + INSN_BYTES` (the address after the faulting or calling instruction, wrapping at the address width) in the target mode's link bank.
- R6: Entry stores the status value from before the entry in the target mode's saved-status bank.
- R7: Entry always sets the I bit (bit 7). It sets the F bit (bit 6) only for reset and FIQ, and otherwise leaves F and bits 31:8 and 5 unchanged.
- R8: An IRQ request is ignored while status bit 7 is set, and an FIQ request is ignored while bit 6 is set. A lower-priority request may then win.
- R9: A return request in a banked mode produces, one cycle later, `pc_load` high, `pc_out` equal to that mode's link bank and the status equal to its saved-status bank.
- R10: A return request while the mode field holds User or any unbanked code has no effect: no `pc_load`, and the status is unchanged.
- R11: An accepted exception takes precedence over a return request and a status write in the same cycle, and both of those are discarded.
- R12: After hardware reset the status reads 0x000000D3 (Supervisor, I and F set), `pc_load` and `taken` are low and the banks are zero. A status write with no exception or return pending loads `sr_wdata` into the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| req_reset | input | 1 | Reset exception request |
| req_undef | input | 1 | Undefined-instruction request |
| req_swi | input | 1 | Software-interrupt request from a supervisor call |
| req_iabt | input | 1 | Instruction-fetch abort request |
| req_dabt | input | 1 | Data-access abort request |
| req_irq | input | 1 | Normal interrupt request |
| req_fiq | input | 1 | Fast interrupt request |
| pc_now | input | AW | Address of the instruction at which the exception is raised |
| ret_req | input | 1 | Return-from-exception request |
| sr_we | input | 1 | Direct status-register write enable |
| sr_wdata | input | 32 | Direct status-register write value |
| pc_load | output | 1 | Program counter redirect strobe |
| pc_out | output | AW | Redirect target |
| sr_out | output | 32 | Current status register |
| taken | output | 7 | One-hot accepted-exception strobe |

## Verification
The bench builds the block with a 16-bit address and a 4-byte instruction size. This brings the wrap of the return address within reach: an exception at 0xFFFC must save 0x0000. The narrow address also lets random program-counter values land on that edge. Directed steps cover the arbitration order, each vector and mode, both masks, return from every bank, return in User mode and same-cycle collisions. A long random run follows, in which status writes place unbanked mode codes and arbitrary disable bits in front of the arbiter.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int SR_W   = 32;
    localparam int I_BIT  = 7;
    localparam int F_BIT  = 6;
    localparam int MODE_W = 5;
    localparam int NKIND  = 7;
    localparam int NBANK  = 5;
    localparam int BIDX_W = $clog2(NBANK);
    localparam int VOFF_W = 5;

    typedef enum logic [MODE_W-1:0] {
        M_USR = 5'b10000,
        M_FIQ = 5'b10001,
        M_IRQ = 5'b10010,
        M_SVC = 5'b10011,
        M_ABT = 5'b10111,
        M_UND = 5'b11011
    } mode_e;

    // Bit index of each kind in the request and strobe vectors
    typedef enum logic [2:0] {
        K_RST  = 3'd0,
        K_UND  = 3'd1,
        K_SWI  = 3'd2,
        K_IABT = 3'd3,
        K_DABT = 3'd4,
        K_IRQ  = 3'd5,
        K_FIQ  = 3'd6
    } kind_e;

    // Kind that sits at a given rank, rank 0 being the strongest
    function automatic kind_e kind_at_rank(input int r);
        case (r)
            0:       return K_RST;
            1:       return K_DABT;
            2:       return K_FIQ;
            3:       return K_IRQ;
            4:       return K_IABT;
            5:       return K_UND;
            default: return K_SWI;
        endcase
    endfunction

    function automatic logic [MODE_W-1:0] target_mode(input kind_e k);
        case (k)
            K_UND:          return M_UND;
            K_IABT, K_DABT: return M_ABT;
            K_IRQ:          return M_IRQ;
            K_FIQ:          return M_FIQ;
            default:        return M_SVC;
        endcase
    endfunction

    function automatic logic [VOFF_W-1:0] vector_of(input kind_e k);
        case (k)
            K_UND:   return 5'h04;
            K_SWI:   return 5'h08;
            K_IABT:  return 5'h0C;
            K_DABT:  return 5'h10;
            K_IRQ:   return 5'h18;
            K_FIQ:   return 5'h1C;
            default: return 5'h00;
        endcase
    endfunction

    // Bank slot of a mode; the top bit flags a mode that owns a bank
    function automatic logic [BIDX_W:0] bank_of(input logic [MODE_W-1:0] m);
        case (m)
            M_FIQ:   return {1'b1, BIDX_W'(0)};
            M_IRQ:   return {1'b1, BIDX_W'(1)};
            M_SVC:   return {1'b1, BIDX_W'(2)};
            M_ABT:   return {1'b1, BIDX_W'(3)};
            M_UND:   return {1'b1, BIDX_W'(4)};
            default: return {1'b0, BIDX_W'(0)};
        endcase
    endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_pkg::*;
(
    input  logic [NKIND-1:0] req,
    input  logic             mask_irq,
    input  logic             mask_fiq,
    output logic             hit,
    output kind_e            kind
);

    logic [NKIND-1:0] live;

    always_comb begin
        live        = req;
        live[K_IRQ] = req[K_IRQ] & ~mask_irq;
        live[K_FIQ] = req[K_FIQ] & ~mask_fiq;
        hit         = |live;
        kind        = K_RST;
        // Walk from weakest to strongest so the strongest live one remains
        for (int r = NKIND - 1; r >= 0; r--) begin
            if (live[kind_at_rank(r)]) kind = kind_at_rank(r);
        end
    end

endmodule

// File: rtl/exc_bank.sv
module exc_bank
    import exc_pkg::*;
#(
    parameter int AW  = 32,
    parameter int NB  = NBANK,
    parameter int IW  = BIDX_W,
    parameter int SRW = SR_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [IW-1:0]  widx,
    input  logic [AW-1:0]  wlr,
    input  logic [SRW-1:0] wspsr,
    input  logic [IW-1:0]  ridx,
    output logic [AW-1:0]  rlr,
    output logic [SRW-1:0] rspsr
);

    typedef struct packed {
        logic [NB-1:0][AW-1:0]  lr;
        logic [NB-1:0][SRW-1:0] spsr;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        for (int b = 0; b < NB; b++) begin
            if (we && (int'(widx) == b)) begin
                bank_d.lr[b]   = wlr;
                bank_d.spsr[b] = wspsr;
            end
        end
        rlr   = '0;
        rspsr = '0;
        for (int b = 0; b < NB; b++) begin
            if (int'(ridx) == b) begin
                rlr   = bank_q.lr[b];
                rspsr = bank_q.spsr[b];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_pkg::*;
#(
    parameter int AW         = 32,
    parameter int INSN_BYTES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_reset,
    input  logic             req_undef,
    input  logic             req_swi,
    input  logic             req_iabt,
    input  logic             req_dabt,
    input  logic             req_irq,
    input  logic             req_fiq,
    input  logic [AW-1:0]    pc_now,
    input  logic             ret_req,
    input  logic             sr_we,
    input  logic [SR_W-1:0]  sr_wdata,
    output logic             pc_load,
    output logic [AW-1:0]    pc_out,
    output logic [SR_W-1:0]  sr_out,
    output logic [NKIND-1:0] taken
);

    localparam logic [SR_W-1:0] SR_RESET = SR_W'({1'b1, 1'b1, 1'b0, M_SVC});

    typedef struct packed {
        logic [SR_W-1:0]  sr;
        logic [AW-1:0]    pc;
        logic             load;
        logic [NKIND-1:0] taken;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NKIND-1:0]  req_vec;
    logic              arb_hit;
    kind_e             arb_kind;
    logic              bk_we;
    logic [BIDX_W-1:0] bk_widx;
    logic [BIDX_W:0]   cur_bank;
    logic [BIDX_W:0]   tgt_bank;
    logic [MODE_W-1:0] tgt_mode;
    logic [AW-1:0]     bk_rlr;
    logic [SR_W-1:0]   bk_rspsr;

    always_comb begin
        req_vec         = '0;
        req_vec[K_RST]  = req_reset;
        req_vec[K_UND]  = req_undef;
        req_vec[K_SWI]  = req_swi;
        req_vec[K_IABT] = req_iabt;
        req_vec[K_DABT] = req_dabt;
        req_vec[K_IRQ]  = req_irq;
        req_vec[K_FIQ]  = req_fiq;
    end

    exc_arbiter u_arb (
        .req      (req_vec),
        .mask_irq (ctl_q.sr[I_BIT]),
        .mask_fiq (ctl_q.sr[F_BIT]),
        .hit      (arb_hit),
        .kind     (arb_kind)
    );

    assign cur_bank = bank_of(ctl_q.sr[MODE_W-1:0]);
    assign tgt_mode = target_mode(arb_kind);
    assign tgt_bank = bank_of(tgt_mode);
    assign bk_we    = arb_hit;
    assign bk_widx  = tgt_bank[BIDX_W-1:0];

    exc_bank #(.AW(AW)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bk_we),
        .widx  (bk_widx),
        .wlr   (pc_now + AW'(INSN_BYTES)),
        .wspsr (ctl_q.sr),
        .ridx  (cur_bank[BIDX_W-1:0]),
        .rlr   (bk_rlr),
        .rspsr (bk_rspsr)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.load  = 1'b0;
        ctl_d.taken = '0;
        if (arb_hit) begin
            ctl_d.sr[MODE_W-1:0] = tgt_mode;
            ctl_d.sr[I_BIT]      = 1'b1;
            if (arb_kind == K_RST || arb_kind == K_FIQ) ctl_d.sr[F_BIT] = 1'b1;
            ctl_d.pc              = AW'(vector_of(arb_kind));
            ctl_d.load            = 1'b1;
            ctl_d.taken[arb_kind] = 1'b1;
        end else if (ret_req && cur_bank[BIDX_W]) begin
            ctl_d.sr   = bk_rspsr;
            ctl_d.pc   = bk_rlr;
            ctl_d.load = 1'b1;
        end else if (sr_we) begin
            ctl_d.sr = sr_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.sr    <= SR_RESET;
        end else begin
            ctl_q       <= ctl_d;
        end
    end

    assign pc_load = ctl_q.load;
    assign pc_out  = ctl_q.pc;
    assign sr_out  = ctl_q.sr;
    assign taken   = ctl_q.taken;

    logic any_req;
    assign any_req = req_reset | req_undef | req_swi | req_iabt | req_dabt | req_irq | req_fiq;

    a_r2_taken_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(taken));

    a_r3_taken_loads_pc: assert property (@(posedge clk) disable iff (!rst_n)
        (|taken) |-> pc_load);

    a_r7_entry_sets_i: assert property (@(posedge clk) disable iff (!rst_n)
        (|taken) |-> sr_out[I_BIT]);

    a_r8_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (req_irq && sr_out[I_BIT]) |=> !taken[K_IRQ]);

    a_r8_fiq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (req_fiq && sr_out[F_BIT]) |=> !taken[K_FIQ]);

    a_r10_user_return_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_req && !any_req && sr_out[MODE_W-1:0] == M_USR) |=> !pc_load);

    a_r12_status_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_req && !ret_req && !sr_we) |=> $stable(sr_out));

endmodule

// File: tb/exc_entry_ctrl_test.sv
module exc_entry_ctrl_test;

    localparam int AW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic i_rst = 0, i_und = 0, i_swi = 0, i_iabt = 0, i_dabt = 0, i_irq = 0, i_fiq = 0;
    logic [AW-1:0] i_pc = '0;
    logic i_ret = 0, i_we = 0;
    logic [31:0] i_wd = '0;
    logic pc_load;
    logic [AW-1:0] pc_out;
    logic [31:0] sr_out;
    logic [6:0] taken;

    int total = 0;
    int bad = 0;
    bit done = 0;
    string tag = "R12";

    always #2 clk = ~clk;

    exc_entry_ctrl #(.AW(AW), .INSN_BYTES(4)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_reset(i_rst), .req_undef(i_und), .req_swi(i_swi), .req_iabt(i_iabt),
        .req_dabt(i_dabt), .req_irq(i_irq), .req_fiq(i_fiq),
        .pc_now(i_pc), .ret_req(i_ret), .sr_we(i_we), .sr_wdata(i_wd),
        .pc_load(pc_load), .pc_out(pc_out), .sr_out(sr_out), .taken(taken)
    );

    // Behavioural reference model
    logic [31:0]   m_sr;
    logic [AW-1:0] m_pc;
    logic          m_load;
    logic [6:0]    m_taken;
    logic [AW-1:0] lr_m [32];
    logic [31:0]   spsr_m [32];

    function automatic int vec_tab(input int k);
        int v[7] = '{0, 4, 8, 12, 16, 24, 28};
        return v[k];
    endfunction

    function automatic logic [4:0] mode_tab(input int k);
        logic [4:0] m[7] = '{5'h13, 5'h1B, 5'h13, 5'h17, 5'h17, 5'h12, 5'h11};
        return m[k];
    endfunction

    function automatic bit banked(input logic [4:0] m);
        return m == 5'h11 || m == 5'h12 || m == 5'h13 || m == 5'h17 || m == 5'h1B;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sr = 32'hD3; m_pc = '0; m_load = 0; m_taken = '0;
            for (int j = 0; j < 32; j++) begin lr_m[j] = '0; spsr_m[j] = '0; end
        end else begin
            int k;
            logic [4:0] md;
            k = -1;
            if (i_rst) k = 0;
            else if (i_dabt) k = 4;
            else if (i_fiq && !m_sr[6]) k = 6;
            else if (i_irq && !m_sr[7]) k = 5;
            else if (i_iabt) k = 3;
            else if (i_und) k = 1;
            else if (i_swi) k = 2;
            m_load = 0; m_taken = '0;
            if (k >= 0) begin
                md = mode_tab(k);
                lr_m[md] = i_pc + AW'(4);
                spsr_m[md] = m_sr;
                m_sr[4:0] = md;
                m_sr[7] = 1'b1;
                if (k == 0 || k == 6) m_sr[6] = 1'b1;
                m_pc = AW'(vec_tab(k));
                m_load = 1;
                m_taken = 7'(1 << k);
            end else if (i_ret && banked(m_sr[4:0])) begin
                md = m_sr[4:0];
                m_pc = lr_m[md];
                m_sr = spsr_m[md];
                m_load = 1;
            end else if (i_we) begin
                m_sr = i_wd;
            end
        end
    end

    task automatic chk(input string t, input string f, input logic [31:0] a, input logic [31:0] e);
        total++;
        if (a !== e) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", t, f, a, e, $time);
        end
    endtask

    task automatic compare();
        chk(tag, "taken", 32'(taken), 32'(m_taken));
        chk(tag, "pc_load", 32'(pc_load), 32'(m_load));
        if (m_load) chk(tag, "pc_out", 32'(pc_out), 32'(m_pc));
        chk(tag, "sr_out", sr_out, m_sr);
    endtask

    task automatic idle();
        i_rst = 0; i_und = 0; i_swi = 0; i_iabt = 0; i_dabt = 0; i_irq = 0; i_fiq = 0;
        i_ret = 0; i_we = 0;
    endtask

    task automatic step();
        @(negedge clk);
        compare();
        idle();
    endtask

    task automatic set_sr(input logic [31:0] v);
        i_we = 1; i_wd = v; step();
    endtask

    task automatic raise(input int k, input logic [AW-1:0] pc);
        i_pc = pc;
        case (k)
            0: i_rst = 1;  1: i_und = 1;  2: i_swi = 1;  3: i_iabt = 1;
            4: i_dabt = 1; 5: i_irq = 1;  default: i_fiq = 1;
        endcase
        step();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        tag = "R12";
        chk("R12", "reset sr", sr_out, 32'hD3);
        chk("R12", "reset load", 32'(pc_load), 0);
        chk("R12", "reset taken", 32'(taken), 0);
        set_sr(32'h0000_0010);
        chk("R12", "sr write", sr_out, 32'h10);

        // R1: drop the strongest request one at a time
        tag = "R1";
        for (int top = 0; top < 7; top++) begin
            int rk[7] = '{0, 4, 6, 5, 3, 1, 2};
            set_sr(32'h0000_0010);
            for (int r = top; r < 7; r++) begin
                case (rk[r])
                    0: i_rst = 1;  1: i_und = (rk[top] != 2); 2: i_swi = 1;
                    3: i_iabt = 1; 4: i_dabt = 1; 5: i_irq = 1; default: i_fiq = 1;
                endcase
            end
            i_pc = 16'h0100;
            step();
            chk("R1", "winner", 32'(taken), 32'(1 << rk[top]));
            step();
            chk("R2", "strobe width", 32'(taken), 0);
        end

        // R3 R4 R5 R6 R9: each kind from User, then return
        for (int k = 0; k < 7; k++) begin
            tag = "R3";
            set_sr(32'h0000_0010 | 32'(k << 8));
            raise(k, AW'(16'h2000 + k * 16));
            chk("R3", "vector", 32'(pc_out), 32'(vec_tab(k)));
            chk("R4", "mode", 32'(sr_out[4:0]), 32'(mode_tab(k)));
            tag = "R9";
            i_ret = 1; step();
            chk("R5", "saved return", 32'(pc_out), 32'(16'h2004 + k * 16));
            chk("R6", "saved status", sr_out, 32'h0000_0010 | 32'(k << 8));
        end

        // R5: return address wraps at the address width
        tag = "R5";
        set_sr(32'h10);
        raise(2, 16'hFFFC);
        i_ret = 1; step();
        chk("R5", "wrap", 32'(pc_out), 0);

        // R7: F kept on IRQ, set on FIQ, I always
        tag = "R7";
        set_sr(32'h50); raise(5, 16'h10);
        chk("R7", "irq keeps F", sr_out, 32'hD2);
        set_sr(32'h10); raise(1, 16'h10);
        chk("R7", "undef F clear", sr_out, 32'h9B);
        set_sr(32'h80); raise(6, 16'h10);
        chk("R7", "fiq sets F", sr_out, 32'hD1);

        // R8: masks
        tag = "R8";
        set_sr(32'h93);
        i_irq = 1; step();
        chk("R8", "irq masked", 32'(taken), 0);
        i_irq = 1; i_iabt = 1; step();
        chk("R8", "lower wins", 32'(taken), 32'h08);
        set_sr(32'h53);
        i_fiq = 1; i_irq = 1; step();
        chk("R8", "fiq masked irq wins", 32'(taken), 32'h20);

        // R10: return in User or unbanked mode
        tag = "R10";
        set_sr(32'h10);
        i_ret = 1; step();
        chk("R10", "user ret", 32'(pc_load), 0);
        chk("R10", "user sr", sr_out, 32'h10);
        set_sr(32'h1F);
        i_ret = 1; step();
        chk("R10", "unbanked ret", 32'(pc_load), 0);

        // R11: entry beats return and write
        tag = "R11";
        set_sr(32'h13);
        i_und = 1; i_ret = 1; i_we = 1; i_wd = 32'h10; i_pc = 16'h0400; step();
        chk("R11", "entry wins", 32'(taken), 32'h02);
        chk("R11", "entry sr", sr_out, 32'h9B);

        // Random run compared every cycle
        tag = "R1R3R7R9";
        for (int n = 0; n < 4000; n++) begin
            int r = $urandom % 32;
            i_rst = ($urandom % 40) == 0; i_und = r == 1; i_swi = r == 2 || r == 9;
            i_iabt = r == 3; i_dabt = r == 4; i_irq = r < 12 && r > 4;
            i_fiq = r == 5 || r == 12;
            i_pc = AW'($urandom);
            if (($urandom % 16) == 0) i_pc = 16'hFFFC;
            i_ret = ($urandom % 4) == 0;
            i_we = ($urandom % 5) == 0;
            i_wd = {$urandom, 5'h0} | 32'((($urandom % 3) == 0) ? 5'h10 : 5'(mode_tab($urandom % 7)));
            step();
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule